// File: doc/BRIEF.md
# Predicated Vector Float Round-to-Integral Unit

This unit takes one 128-bit vector and rounds every lane to an integral value. The result stays in floating-point format. The lanes are either IEEE half-precision (eight lanes of 16 bits) or single-precision (four lanes of 32 bits). A 3-bit operation code picks the rounding direction. It can also pick the dynamic rounding mode supplied from outside, and only that variant reports inexact results.

A byte-granular predicate decides which result bytes land in the destination. The old destination vector is supplied with the operands, and every byte whose predicate bit is clear keeps its old value. The lowest predicate bit of each lane gates that lane's exception flags. A lane can therefore write part of its result while it stays silent in the sticky invalid and inexact flags.

The unit is a two-stage pipeline. It accepts a new operation on every cycle. A single-cycle done strobe marks the cycle in which the merged vector and the updated flags are valid.

Top module: `vrint_vec`

## Requirements
- R1: `size_i`=1 selects eight half lanes and `size_i`=2 selects four single lanes. Lane e occupies bits [e*L +: L], where L is the lane width in bits. Size codes 0 and 3 and op codes 100 and 110 are rejected: `illegal_o` is 1 with done, `result_o` equals the old vector, and no flag changes. A legal operation returns `illegal_o`=0.
- R2: The op codes select fixed rounding directions: 000 rounds to nearest with ties to even, 010 to nearest with ties away from zero, 011 toward zero, 101 toward minus infinity and 111 toward plus infinity.
- R3: Op 001 rounds with `dyn_rm_i` (00 nearest-even, 01 toward plus infinity, 10 toward minus infinity, 11 toward zero). It is the only op that sets inexact, and it sets it when a lane's result differs from its input.
- R4: `pred_i` bit b governs result byte b (bits [8b +: 8]). Lane e spans predicate bits e*B to e*B+B-1, where B is the lane width in bytes. A byte with a clear bit keeps the old destination byte.
- R5: A lane whose predicate bits are all zero leaves its destination bytes unchanged and raises no flag.
- R6: A lane whose lowest predicate bit is zero while another of its bits is set still merges its result into the enabled bytes, but it raises no flag.
- R7: Zero and infinity pass through unchanged with their sign. A result that rounds to zero keeps the input sign.
- R8: A signalling NaN (exponent all ones, mantissa nonzero, top mantissa bit 0) returns with the top mantissa bit set and sets invalid. A quiet NaN returns unchanged and sets no flag.
- R9: An input whose unbiased exponent is at least the mantissa width (10 for half, 23 for single) returns unchanged and never sets inexact.
- R10: A magnitude below one gives a signed zero or a signed one, depending on the direction. Under ties-to-even exactly 0.5 goes to zero; under ties-away it goes to one.
- R11: A start sampled at rising edge k gives `done_o`=1 for exactly the cycle after edge k+1. `done_o` is 0 when no start was sampled at the previous edge.
- R12: `flg_inv_o` and `flg_inx_o` are sticky OR accumulations, cleared only by `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Operation strobe; the operands are sampled with it |
| size_i | input | 2 | Lane size code |
| op_i | input | 3 | Rounding operation code |
| dyn_rm_i | input | 2 | Dynamic rounding mode used by op 001 |
| pred_i | input | 16 | Per-byte write predicate |
| src_i | input | 128 | Source vector |
| old_i | input | 128 | Old destination vector |
| result_o | output | 128 | Merged result vector |
| flg_inv_o | output | 1 | Sticky invalid flag |
| flg_inx_o | output | 1 | Sticky inexact flag |
| illegal_o | output | 1 | Last completed operation was rejected |
| done_o | output | 1 | Result valid strobe |

## Verification
Each lane holds no state beyond the pipeline registers, so a wrong rounding decision in a lane shows up in `result_o` in the done cycle of that same operation. A bad increment shows as a value one unit of the last kept integer bit away from the expected one. A bad tie choice shows only on exact halves, so those inputs are driven on purpose. A corrupt predicate or flag-gating path appears either as old bytes where new ones belong or as a sticky flag that rises on an operation that should stay silent. Because the flags never clear, such an error stays visible at the ports until the next reset, and the bench resets before every flag scenario so that the offending operation can be named.

// File: rtl/vrint_pkg.sv
package vrint_pkg;
  localparam int HEW = 5;
  localparam int HMW = 10;
  localparam int SEW = 8;
  localparam int SMW = 23;

  // Low four encodings line up with the 2-bit dynamic mode input.
  typedef enum logic [2:0] {
    RD_NEAR_EVEN = 3'd0,
    RD_UP        = 3'd1,
    RD_DOWN      = 3'd2,
    RD_ZERO      = 3'd3,
    RD_NEAR_AWAY = 3'd4
  } rdir_e;
endpackage

// File: rtl/vrint_decode.sv
module vrint_decode
  import vrint_pkg::*;
(
  input  logic [1:0] size_i,
  input  logic [2:0] op_i,
  input  logic [1:0] dyn_rm_i,
  output rdir_e      dir_o,
  output logic       inx_en_o,
  output logic       half_o,
  output logic       illegal_o
);
  logic bad_size;
  logic bad_op;

  always_comb begin
    bad_size = (size_i == 2'd0) || (size_i == 2'd3);
    bad_op   = (op_i == 3'b100) || (op_i == 3'b110);
    half_o   = (size_i == 2'd1);
    inx_en_o = (op_i == 3'b001);
    unique case (op_i)
      3'b000:  dir_o = RD_NEAR_EVEN;
      3'b001:  dir_o = rdir_e'({1'b0, dyn_rm_i});
      3'b010:  dir_o = RD_NEAR_AWAY;
      3'b011:  dir_o = RD_ZERO;
      3'b101:  dir_o = RD_DOWN;
      3'b111:  dir_o = RD_UP;
      default: dir_o = RD_ZERO;
    endcase
    illegal_o = bad_size || bad_op;
  end
endmodule

// File: rtl/vrint_lane.sv
module vrint_lane
  import vrint_pkg::*;
#(
  parameter int EW = 5,
  parameter int MW = 10
) (
  input  logic [EW+MW:0] x_i,
  input  rdir_e          dir_i,
  input  logic           inx_en_i,
  input  logic           flag_en_i,
  output logic [EW+MW:0] y_o,
  output logic           inv_o,
  output logic           inx_o
);
  localparam int LW   = 1 + EW + MW;
  localparam int MAGW = EW + MW;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam logic [EW-1:0]   EX_ONE  = EW'(BIAS);
  localparam logic [EW-1:0]   EX_HALF = EW'(BIAS - 1);
  localparam logic [EW-1:0]   EX_INT  = EW'(BIAS + MW);
  localparam logic [EW-1:0]   E_ONE   = EW'(1);
  localparam logic [MAGW-1:0] M_ONE   = MAGW'(1);
  localparam logic [MAGW-1:0] ONE_MAG = {EX_ONE, {MW{1'b0}}};

  logic            sgn;
  logic [EW-1:0]   ex;
  logic [MW-1:0]   man;
  logic [MAGW-1:0] mag;
  logic [EW-1:0]   sh;
  logic [MAGW-1:0] fmask;
  logic [MAGW-1:0] frac;
  logic [MAGW-1:0] half;
  logic            lsb;
  logic            inc;
  logic            up;
  logic            inv;
  logic            inx;

  assign sgn = x_i[LW-1];
  assign ex  = x_i[LW-2:MW];
  assign man = x_i[MW-1:0];
  assign mag = x_i[LW-2:0];

  always_comb begin
    y_o   = x_i;
    inv   = 1'b0;
    inx   = 1'b0;
    up    = 1'b0;
    inc   = 1'b0;
    sh    = EX_INT - ex;
    fmask = (M_ONE << sh) - M_ONE;
    frac  = mag & fmask;
    half  = M_ONE << (sh - E_ONE);
    // For unbiased exponent 0 this bit is the exponent LSB; the biased
    // exponent is odd there, matching the hidden 1 of the integer part.
    lsb   = |(mag & (M_ONE << sh));
    if (ex == '1) begin
      if ((man != '0) && !man[MW-1]) begin
        y_o[MW-1] = 1'b1;
        inv       = 1'b1;
      end
    end else if (ex >= EX_INT) begin
      y_o = x_i;
    end else if (ex < EX_ONE) begin
      if (mag != '0) begin
        inx = 1'b1;
        unique case (dir_i)
          RD_NEAR_EVEN: up = (ex == EX_HALF) && (man != '0);
          RD_NEAR_AWAY: up = (ex == EX_HALF);
          RD_UP:        up = !sgn;
          RD_DOWN:      up = sgn;
          default:      up = 1'b0;
        endcase
        y_o = {sgn, up ? ONE_MAG : {MAGW{1'b0}}};
      end
    end else begin
      inx = (frac != '0);
      unique case (dir_i)
        RD_NEAR_EVEN: inc = (frac > half) || ((frac == half) && lsb);
        RD_NEAR_AWAY: inc = (frac >= half);
        RD_UP:        inc = !sgn && inx;
        RD_DOWN:      inc = sgn && inx;
        default:      inc = 1'b0;
      endcase
      y_o = {sgn, (mag & ~fmask) + (inc ? (fmask + M_ONE) : {MAGW{1'b0}})};
    end
  end

  assign inv_o = inv && flag_en_i;
  assign inx_o = inx && inx_en_i && flag_en_i;
endmodule

// File: rtl/vrint_merge.sv
module vrint_merge #(
  parameter int NB = 16
) (
  input  logic [8*NB-1:0] new_i,
  input  logic [8*NB-1:0] old_i,
  input  logic [NB-1:0]   pred_i,
  input  logic            hold_i,
  output logic [8*NB-1:0] out_o
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign out_o[8*b +: 8] = (pred_i[b] && !hold_i) ? new_i[8*b +: 8]
                                                     : old_i[8*b +: 8];
  end
endmodule

// File: rtl/vrint_vec.sv
module vrint_vec
  import vrint_pkg::*;
#(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [1:0]    size_i,
  input  logic [2:0]    op_i,
  input  logic [1:0]    dyn_rm_i,
  input  logic [VW/8-1:0] pred_i,
  input  logic [VW-1:0] src_i,
  input  logic [VW-1:0] old_i,
  output logic [VW-1:0] result_o,
  output logic          flg_inv_o,
  output logic          flg_inx_o,
  output logic          illegal_o,
  output logic          done_o
);
  localparam int NB  = VW / 8;
  localparam int HLW = 1 + HEW + HMW;
  localparam int SLW = 1 + SEW + SMW;
  localparam int NH  = VW / HLW;
  localparam int NS  = VW / SLW;
  localparam int HB  = HLW / 8;
  localparam int SB  = SLW / 8;

  rdir_e dec_dir;
  logic  dec_inx_en, dec_half, dec_ill;

  vrint_decode u_dec (
    .size_i   (size_i),
    .op_i     (op_i),
    .dyn_rm_i (dyn_rm_i),
    .dir_o    (dec_dir),
    .inx_en_o (dec_inx_en),
    .half_o   (dec_half),
    .illegal_o(dec_ill)
  );

  // Stage A: operand capture.
  logic          vld_a, half_a, ill_a, inxen_a;
  rdir_e         dir_a;
  logic [NB-1:0] pred_a;
  logic [VW-1:0] src_a, old_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_a   <= 1'b0;
      half_a  <= 1'b0;
      ill_a   <= 1'b0;
      inxen_a <= 1'b0;
      dir_a   <= RD_NEAR_EVEN;
      pred_a  <= '0;
      src_a   <= '0;
      old_a   <= '0;
    end else begin
      vld_a <= start_i;
      if (start_i) begin
        half_a  <= dec_half;
        ill_a   <= dec_ill;
        inxen_a <= dec_inx_en;
        dir_a   <= dec_dir;
        pred_a  <= pred_i;
        src_a   <= src_i;
        old_a   <= old_i;
      end
    end
  end

  // Lane arrays for both widths; the size picks one.
  logic [VW-1:0] res_h, res_s;
  logic [NH-1:0] inv_h, inx_h, lo_h;
  logic [NS-1:0] inv_s, inx_s, lo_s;

  for (genvar g = 0; g < NH; g++) begin : g_half
    assign lo_h[g] = pred_a[HB*g];
    vrint_lane #(.EW(HEW), .MW(HMW)) u_lane (
      .x_i      (src_a[HLW*g +: HLW]),
      .dir_i    (dir_a),
      .inx_en_i (inxen_a),
      .flag_en_i(lo_h[g]),
      .y_o      (res_h[HLW*g +: HLW]),
      .inv_o    (inv_h[g]),
      .inx_o    (inx_h[g])
    );
  end

  for (genvar g = 0; g < NS; g++) begin : g_single
    assign lo_s[g] = pred_a[SB*g];
    vrint_lane #(.EW(SEW), .MW(SMW)) u_lane (
      .x_i      (src_a[SLW*g +: SLW]),
      .dir_i    (dir_a),
      .inx_en_i (inxen_a),
      .flag_en_i(lo_s[g]),
      .y_o      (res_s[SLW*g +: SLW]),
      .inv_o    (inv_s[g]),
      .inx_o    (inx_s[g])
    );
  end

  logic [VW-1:0] new_vec, merged;
  logic          lane_inv, lane_inx, lo_any;

  assign new_vec  = half_a ? res_h : res_s;
  assign lane_inv = half_a ? |inv_h : |inv_s;
  assign lane_inx = half_a ? |inx_h : |inx_s;
  assign lo_any   = half_a ? |lo_h : |lo_s;

  vrint_merge #(.NB(NB)) u_merge (
    .new_i (new_vec),
    .old_i (old_a),
    .pred_i(pred_a),
    .hold_i(ill_a),
    .out_o (merged)
  );

  // Stage B: registered outputs and sticky flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      flg_inv_o <= 1'b0;
      flg_inx_o <= 1'b0;
      illegal_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= vld_a;
      if (vld_a) begin
        result_o  <= merged;
        illegal_o <= ill_a;
        if (!ill_a) begin
          flg_inv_o <= flg_inv_o | lane_inv;
          flg_inx_o <= flg_inx_o | lane_inx;
        end
      end
    end
  end

  p_done_follow_r11: assert property (@(posedge clk) disable iff (rst)
    vld_a |=> done_o);
  p_done_only_r11: assert property (@(posedge clk) disable iff (rst)
    !vld_a |=> !done_o);
  p_sticky_inv_r12: assert property (@(posedge clk) disable iff (rst)
    flg_inv_o |=> flg_inv_o);
  p_sticky_inx_r12: assert property (@(posedge clk) disable iff (rst)
    flg_inx_o |=> flg_inx_o);
  p_illegal_keep_r1: assert property (@(posedge clk) disable iff (rst)
    (vld_a && ill_a) |=> (result_o == $past(old_a)) && illegal_o
                         && $stable(flg_inv_o) && $stable(flg_inx_o));
  p_no_pred_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (vld_a && (pred_a == '0)) |=> result_o == $past(old_a));
  p_flag_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (vld_a && !lo_any) |=> $stable(flg_inv_o) && $stable(flg_inx_o));
endmodule

// File: tb/vrint_vec_bench.sv
module vrint_vec_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [1:0]   size_i = 2'd1;
  logic [2:0]   op_i = 3'd0;
  logic [1:0]   dyn_rm_i = 2'd0;
  logic [15:0]  pred_i = '0;
  logic [127:0] src_i = '0;
  logic [127:0] old_i = '0;
  logic [127:0] result_o;
  logic         flg_inv_o, flg_inx_o, illegal_o, done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  vrint_vec u_vrint_vec (
    .clk(clk), .rst(rst), .start_i(start_i), .size_i(size_i), .op_i(op_i),
    .dyn_rm_i(dyn_rm_i), .pred_i(pred_i), .src_i(src_i), .old_i(old_i),
    .result_o(result_o), .flg_inv_o(flg_inv_o), .flg_inx_o(flg_inx_o),
    .illegal_o(illegal_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [127:0] got,
                     input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [127:0] merge(input logic [127:0] nv,
                                         input logic [127:0] ov,
                                         input logic [15:0] p);
    logic [127:0] r;
    for (int b = 0; b < 16; b++) r[8*b +: 8] = p[b] ? nv[8*b +: 8] : ov[8*b +: 8];
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Drives one operation and samples the done cycle (R11).
  task automatic run(input logic [1:0] sz, input logic [2:0] op,
                     input logic [1:0] dyn, input logic [15:0] p,
                     input logic [127:0] src, input logic [127:0] old);
    @(negedge clk);
    size_i = sz; op_i = op; dyn_rm_i = dyn; pred_i = p;
    src_i = src; old_i = old; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk("R11 done low one cycle after start", {127'd0, done_o}, 128'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R11 done high", {127'd0, done_o}, 128'd1);
  endtask

  task automatic check_flags(input string req, input logic inv, input logic inx);
    chk({req, " invalid"}, {127'd0, flg_inv_o}, {127'd0, inv});
    chk({req, " inexact"}, {127'd0, flg_inx_o}, {127'd0, inx});
  endtask

  // Half lanes 0..7: 2.5 1.5 0.5 0.75 -2.5 -0.25 1025 +inf
  localparam logic [127:0] HSRC = {16'h7C00, 16'h6401, 16'hB400, 16'hC100,
                                   16'h3A00, 16'h3800, 16'h3E00, 16'h4100};

  task automatic t_reset();
    chk("R11 reset done", {127'd0, done_o}, 128'd0);
    chk("R12 reset result", result_o, 128'd0);
    check_flags("R12 reset", 1'b0, 1'b0);
    chk("R1 reset illegal", {127'd0, illegal_o}, 128'd0);
  endtask

  task automatic t_half_fixed();
    do_reset();
    run(2'd1, 3'b000, 2'd0, 16'hFFFF, HSRC, '0);
    chk("R2 R7 R9 R10 half nearest-even", result_o,
        {16'h7C00, 16'h6401, 16'h8000, 16'hC000,
         16'h3C00, 16'h0000, 16'h4000, 16'h4000});
    chk("R1 legal op not illegal", {127'd0, illegal_o}, 128'd0);
    run(2'd1, 3'b010, 2'd0, 16'hFFFF, HSRC, '0);
    chk("R2 R10 half ties-away", result_o,
        {16'h7C00, 16'h6401, 16'h8000, 16'hC200,
         16'h3C00, 16'h3C00, 16'h4000, 16'h4200});
    run(2'd1, 3'b011, 2'd0, 16'hFFFF, HSRC, '0);
    chk("R2 R7 half toward zero", result_o,
        {16'h7C00, 16'h6401, 16'h8000, 16'hC000,
         16'h0000, 16'h0000, 16'h3C00, 16'h4000});
    check_flags("R3 fixed ops raise no inexact", 1'b0, 1'b0);
  endtask

  task automatic t_single_dir();
    logic [127:0] s;
    s = {32'hBE800000, 32'h3FD9999A, 32'hBFC00000, 32'h40200000};
    run(2'd2, 3'b101, 2'd0, 16'hFFFF, s, '0);
    chk("R2 R10 single toward minus inf", result_o,
        {32'hBF800000, 32'h3F800000, 32'hC0000000, 32'h40000000});
    run(2'd2, 3'b111, 2'd0, 16'hFFFF, s, '0);
    chk("R2 R7 single toward plus inf", result_o,
        {32'h80000000, 32'h40000000, 32'hBF800000, 32'h40400000});
  endtask

  task automatic t_nan();
    do_reset();
    run(2'd2, 3'b000, 2'd0, 16'hFFFF,
        {32'h7F800000, 32'h80000000, 32'h4B000001, 32'h7F800001}, '0);
    chk("R8 R9 R7 single special values", result_o,
        {32'h7F800000, 32'h80000000, 32'h4B000001, 32'h7FC00001});
    check_flags("R8 signalling NaN", 1'b1, 1'b0);
    do_reset();
    run(2'd1, 3'b000, 2'd0, 16'hFFFF,
        {{6{16'h4000}}, 16'hFE00, 16'h7E00}, '0);
    chk("R8 quiet NaN unchanged", result_o, {{6{16'h4000}}, 16'hFE00, 16'h7E00});
    check_flags("R8 quiet NaN", 1'b0, 1'b0);
  endtask

  task automatic t_dynamic();
    do_reset();
    run(2'd1, 3'b001, 2'd0, 16'hFFFF, {{7{16'h4000}}, 16'h6401}, '0);
    chk("R3 R9 integral input", result_o, {{7{16'h4000}}, 16'h6401});
    check_flags("R3 R9 integral input", 1'b0, 1'b0);
    run(2'd1, 3'b001, 2'd1, 16'hFFFF, {8{16'h4100}}, '0);
    chk("R3 dynamic plus inf", result_o, {8{16'h4200}});
    check_flags("R3 dynamic inexact", 1'b0, 1'b1);
    run(2'd1, 3'b001, 2'd2, 16'hFFFF, {8{16'hC100}}, '0);
    chk("R3 dynamic minus inf", result_o, {8{16'hC200}});
    run(2'd1, 3'b001, 2'd3, 16'hFFFF, {8{16'h4100}}, '0);
    chk("R3 dynamic toward zero", result_o, {8{16'h4000}});
    run(2'd1, 3'b001, 2'd0, 16'hFFFF, {8{16'h4000}}, '0);
    check_flags("R12 inexact stays sticky", 1'b0, 1'b1);
  endtask

  task automatic t_pred();
    logic [127:0] s, o, n;
    do_reset();
    s = {{4{16'h4100}}, 16'h7C01, 16'h7C01, 16'h4100, 16'h4100};
    n = {{4{16'h4000}}, 16'h7E01, 16'h7E01, 16'h4000, 16'h4000};
    o = {8{16'hAAAA}};
    run(2'd1, 3'b000, 2'd0, 16'hFF27, s, o);
    chk("R4 R5 R6 byte merge", result_o, merge(n, o, 16'hFF27));
    chk("R6 partial lane bytes", result_o[63:16], {16'hAAAA, 16'h7EAA, 16'hAA00});
    check_flags("R5 R6 suppressed lanes", 1'b0, 1'b0);
    run(2'd1, 3'b000, 2'd0, 16'h0000, s, o);
    chk("R5 empty predicate keeps destination", result_o, o);
    check_flags("R5 empty predicate", 1'b0, 1'b0);
    run(2'd1, 3'b000, 2'd0, 16'h0010, s, o);
    check_flags("R4 lowest lane bit enables flags", 1'b1, 1'b0);
    chk("R4 single byte written", result_o, merge(n, o, 16'h0010));
  endtask

  task automatic t_illegal();
    logic [127:0] s, o;
    s = {{4{32'h7F800001}}};
    o = {4{32'h12345678}};
    do_reset();
    run(2'd0, 3'b000, 2'd0, 16'hFFFF, s, o);
    chk("R1 size 0 keeps destination", result_o, o);
    chk("R1 size 0 illegal", {127'd0, illegal_o}, 128'd1);
    run(2'd3, 3'b000, 2'd0, 16'hFFFF, s, o);
    chk("R1 size 3 illegal", {127'd0, illegal_o}, 128'd1);
    chk("R1 size 3 keeps destination", result_o, o);
    run(2'd2, 3'b100, 2'd0, 16'hFFFF, s, o);
    chk("R1 op 100 illegal", {127'd0, illegal_o}, 128'd1);
    run(2'd2, 3'b110, 2'd0, 16'hFFFF, s, o);
    chk("R1 op 110 keeps destination", result_o, o);
    check_flags("R1 rejected ops raise no flag", 1'b0, 1'b0);
    run(2'd2, 3'b000, 2'd0, 16'hFFFF, s, o);
    chk("R1 legal after illegal", {127'd0, illegal_o}, 128'd0);
    check_flags("R12 invalid sets", 1'b1, 1'b0);
    run(2'd2, 3'b000, 2'd0, 16'hFFFF, {4{32'h40000000}}, o);
    check_flags("R12 invalid stays sticky", 1'b1, 1'b0);
  endtask

  task automatic t_gap();
    @(negedge clk);
    chk("R11 done pulse is one cycle", {127'd0, done_o}, 128'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_half_fixed();
    t_gap();
    t_single_dir();
    t_nan();
    t_dynamic();
    t_pred();
    t_illegal();
    t_gap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule